// File: doc/BRIEF.md
# Dual-Slope Conversion Cycle Sequencer

This block is the digital controller of a dual-slope integrating converter. It runs every measurement through four phases (auto-zero, signal integrate, de-integrate, zero-integrator). It drives one select line per phase to the external analog switches. During de-integrate it counts clocks into a five-digit BCD reading until the registered comparator bit shows that the integrator has crossed zero. Once per conversion it latches the reading with its sign, overrange and underrange flags, and a one-clock ready pulse.

A run/hold input chooses between free-running conversions at a fixed period and single conversions. When held, the block finishes the cycle in progress and then parks in auto-zero, keeping the last reading. The comparator bit is taken as already synchronous. It is high when the integrator output is on the positive side.

Top module: `dslope_seq`

## Requirements
- R1: `phase_sel_o` is one-hot, with bit 0 = auto-zero, bit 1 = signal integrate, bit 2 = de-integrate and bit 3 = zero-integrator. Phases only advance in the order auto-zero, integrate, de-integrate, zero-integrator, auto-zero.
- R2: Signal integrate lasts exactly `INT_LEN` clocks. With `run_hold_i` high, integrate phases begin every `CYCLE_LEN` clocks (default 40,002).
- R3: If `run_hold_i` is low on the last clock of a cycle, the block stays in auto-zero for as long as it remains low. The reading outputs and flags do not change while it waits.
- R4: While waiting, a clock with `run_hold_i` high starts signal integrate on the next clock. A high pulse that ends before the running cycle completes starts nothing.
- R5: The reading counter is cleared when de-integrate begins and is held on its first clock. It advances by one on each later de-integrate clock for which `cmp_i` still equals the latched sign. De-integrate ends on the first clock where `cmp_i` differs from the sign. A crossing seen on de-integrate clock t (counting from 0) therefore gives a reading of max(t-1, 0).
- R6: If no crossing is seen within `DE_LEN` clocks (default 20,001), de-integrate ends and the conversion is overrange, with reading `DE_LEN-1`. Zero-integrator then lasts `ZI_OVR_LEN` clocks (default 6,200) instead of `ZI_LEN` (default 200).
- R7: `busy_o` is high exactly during integrate and de-integrate. It falls on the clock after the crossing or timeout.
- R8: One clock after `busy_o` falls, `bcd_o` (digit k in bits 4k+3..4k, digit 0 least significant) and the flags take the new result and `rdy_o` is high for that single clock. `bcd_o` changes at no other time.
- R9: `ovr_o` is set with the result of an overrange conversion and cleared on the first clock of the next de-integrate phase.
- R10: `und_o` is set with a result of `UND_LIM` (default 1,800) or less that is not overrange. It is cleared on the first clock of the next integrate phase.
- R11: `pol_o` takes the value of `cmp_i` on the last integrate clock (1 = positive). It changes only on the first clock of de-integrate and stays valid for a zero reading.
- R12: After a synchronous active-low reset the block is in auto-zero and waiting, with `busy_o`, `bcd_o`, `pol_o`, `ovr_o`, `und_o` and `rdy_o` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_hold_i | input | 1 | High: free-run; low: hold after the current cycle; high while holding: start |
| cmp_i | input | 1 | Registered comparator, 1 = integrator positive |
| phase_sel_o | output | 4 | One-hot phase select for the analog switches |
| busy_o | output | 1 | High during integrate and de-integrate |
| bcd_o | output | 4*NDIG | Latched BCD reading |
| pol_o | output | 1 | Sign of the last conversion, 1 = positive |
| ovr_o | output | 1 | Overrange flag |
| und_o | output | 1 | Underrange flag |
| rdy_o | output | 1 | One-clock pulse when a new result is latched |

## Verification
A corrupted phase or tick counter moves a phase edge, and that shows at once on `phase_sel_o` and `busy_o` on the clock where the edge should have been. A bad reading counter or a wrong inhibit shows in `bcd_o` one clock after busy falls, so within one conversion. A wrong latched sign shifts the de-integrate end and appears in `pol_o` at the start of de-integrate. Bad hold logic shows on the first clock where the block starts or fails to start integrate. The bench drives crossing ticks at zero, at the underrange limit, on the last allowed tick and never, with both signs, and compares every output with a reference model on every clock.

// File: rtl/dss_pkg.sv
// Package: types shared by the dual-slope sequencer.
// Assumes: phase encoding order matches the conversion order.
package dss_pkg;

    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DE  = 2'd2,
        PH_ZI  = 2'd3
    } phase_t;

endpackage

// File: rtl/dss_phase_ctl.sv
// Module: phase controller.
// Steps auto-zero -> integrate -> de-integrate -> zero-integrator and keeps
// the cycle position for the fixed period. It decides when to hold, latches
// the sign at the end of integrate and flags timeout (overrange).
// Assumes: cmp_i is synchronous to clk;
// CYCLE_LEN > INT_LEN + DE_LEN + ZI_OVR_LEN.
module dss_phase_ctl
    import dss_pkg::*;
#(
    parameter int CYCLE_LEN  = 40002,
    parameter int INT_LEN    = 10000,
    parameter int DE_LEN     = 20001,
    parameter int ZI_LEN     = 200,
    parameter int ZI_OVR_LEN = 6200
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_hold_i,
    input  logic   cmp_i,
    output phase_t phase_o,
    output logic   pol_o,
    output logic   ovr_cyc_o,
    output logic   int_start_o,
    output logic   de_start_o,
    output logic   de_end_o,
    output logic   cnt_inc_o
);

    localparam int PW = $clog2(CYCLE_LEN + 1);
    localparam logic [PW-1:0] CYC_LAST = PW'(CYCLE_LEN - 1);
    localparam logic [PW-1:0] INT_LAST = PW'(INT_LEN - 1);
    localparam logic [PW-1:0] DE_LAST  = PW'(DE_LEN - 1);
    localparam logic [PW-1:0] ZI_LAST  = PW'(ZI_LEN - 1);
    localparam logic [PW-1:0] ZO_LAST  = PW'(ZI_OVR_LEN - 1);

    phase_t          st_q;
    logic [PW-1:0]   pos_q;
    logic [PW-1:0]   tick_q;
    logic            hold_q;
    logic            pol_q;
    logic            ovr_q;

    logic            cyc_done;
    logic            zc;
    logic            zi_done;
    logic            hold_set;

    // Phase transition conditions for the current clock.
    always_comb begin
        cyc_done    = hold_q || (pos_q == CYC_LAST);
        zc          = cmp_i ^ pol_q;
        int_start_o = (st_q == PH_AZ) && cyc_done && run_hold_i;
        hold_set    = (st_q == PH_AZ) && cyc_done && !run_hold_i;
        de_start_o  = (st_q == PH_INT) && (tick_q == INT_LAST);
        de_end_o    = (st_q == PH_DE) && (zc || (tick_q == DE_LAST));
        cnt_inc_o   = (st_q == PH_DE) && !zc && (tick_q != '0);
        zi_done     = (st_q == PH_ZI) && (tick_q == (ovr_q ? ZO_LAST : ZI_LAST));
    end

    // Phase state register.
    always_ff @(posedge clk) begin
        if (!rst_n)           st_q <= PH_AZ;
        else if (int_start_o) st_q <= PH_INT;
        else if (de_start_o)  st_q <= PH_DE;
        else if (de_end_o)    st_q <= PH_ZI;
        else if (zi_done)     st_q <= PH_AZ;
    end

    // Position within the fixed-length cycle, counted from integrate start.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pos_q <= '0;
        else if (int_start_o)                    pos_q <= '0;
        else if (!((st_q == PH_AZ) && cyc_done)) pos_q <= pos_q + 1'b1;
    end

    // Clocks spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                                           tick_q <= '0;
        else if (int_start_o || de_start_o || de_end_o || zi_done) tick_q <= '0;
        else if (st_q != PH_AZ)                               tick_q <= tick_q + 1'b1;
    end

    // Holding flag: set when a cycle ends with run/hold low.
    always_ff @(posedge clk) begin
        if (!rst_n)           hold_q <= 1'b1;
        else if (int_start_o) hold_q <= 1'b0;
        else if (hold_set)    hold_q <= 1'b1;
    end

    // Sign latched at the end of integrate.
    always_ff @(posedge clk) begin
        if (!rst_n)          pol_q <= 1'b0;
        else if (de_start_o) pol_q <= cmp_i;
    end

    // Overrange of this conversion: de-integrate ended without a crossing.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovr_q <= 1'b0;
        else if (de_end_o) ovr_q <= !zc;
    end

    assign phase_o   = st_q;
    assign pol_o     = pol_q;
    assign ovr_cyc_o = ovr_q;

endmodule

// File: rtl/dss_bcd_counter.sv
// Module: synchronous decade counter with NDIG BCD digits.
// Clear has priority over increment; digits ripple-carry on 9 -> 0.
// Assumes: the counted range never exceeds 10**NDIG - 1.
module dss_bcd_counter #(
    parameter int NDIG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [4*NDIG-1:0] bcd_o
);

    logic [NDIG:0] carry;

    assign carry[0] = inc_i;

    for (genvar d = 0; d < NDIG; d++) begin : g_digit
        logic [3:0] dig_q;

        // Carry out when this digit wraps.
        assign carry[d+1] = carry[d] && (dig_q == 4'd9);

        // One decade of the reading.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i)  dig_q <= 4'd0;
            else if (carry[d])    dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
        end

        assign bcd_o[4*d +: 4] = dig_q;
    end

endmodule

// File: rtl/dss_result_reg.sv
// Module: result latch and range flags.
// Loads the reading one clock after de-integrate ends, pulses ready, sets
// the overrange/underrange flags and clears them at their phase starts.
// Assumes: a load never coincides with an integrate or de-integrate start.
module dss_result_reg #(
    parameter int NDIG    = 5,
    parameter int UND_LIM = 1800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              de_end_i,
    input  logic              ovr_cyc_i,
    input  logic              int_start_i,
    input  logic              de_start_i,
    input  logic [4*NDIG-1:0] cnt_i,
    output logic [4*NDIG-1:0] bcd_o,
    output logic              ovr_o,
    output logic              und_o,
    output logic              rdy_o
);

    localparam int BW = 4 * NDIG;

    logic          load_q;
    logic [BW-1:0] cnt_bin;
    logic          is_low;

    // Binary value of the running count, for the underrange compare.
    always_comb begin
        cnt_bin = '0;
        for (int d = NDIG - 1; d >= 0; d--) begin
            cnt_bin = BW'(cnt_bin * BW'(10)) + BW'(cnt_i[4*d +: 4]);
        end
        is_low = (cnt_bin <= BW'(UND_LIM)) && !ovr_cyc_i;
    end

    // Load strobe: the clock after busy falls.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= de_end_i;
    end

    // Latched reading and ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcd_o <= '0;
            rdy_o <= 1'b0;
        end else begin
            rdy_o <= load_q;
            if (load_q) bcd_o <= cnt_i;
        end
    end

    // Overrange flag: set on load, cleared at de-integrate start.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovr_o <= 1'b0;
        else if (de_start_i) ovr_o <= 1'b0;
        else if (load_q)     ovr_o <= ovr_cyc_i;
    end

    // Underrange flag: set on load, cleared at integrate start.
    always_ff @(posedge clk) begin
        if (!rst_n)           und_o <= 1'b0;
        else if (int_start_i) und_o <= 1'b0;
        else if (load_q)      und_o <= is_low;
    end

endmodule

// File: rtl/dslope_seq.sv
// Module: dual-slope conversion cycle sequencer (top).
// Ties the phase controller, BCD reading counter and result latch together
// and decodes the phase into one-hot switch selects and busy.
// Assumes: cmp_i already synchronous; outputs feed switch drivers directly.
module dslope_seq
    import dss_pkg::*;
#(
    parameter int NDIG       = 5,
    parameter int CYCLE_LEN  = 40002,
    parameter int INT_LEN    = 10000,
    parameter int DE_LEN     = 20001,
    parameter int ZI_LEN     = 200,
    parameter int ZI_OVR_LEN = 6200,
    parameter int UND_LIM    = 1800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_hold_i,
    input  logic              cmp_i,
    output logic [3:0]        phase_sel_o,
    output logic              busy_o,
    output logic [4*NDIG-1:0] bcd_o,
    output logic              pol_o,
    output logic              ovr_o,
    output logic              und_o,
    output logic              rdy_o
);

    phase_t            phase;
    logic              ovr_cyc;
    logic              int_start;
    logic              de_start;
    logic              de_end;
    logic              cnt_inc;
    logic [4*NDIG-1:0] cnt_bcd;

    dss_phase_ctl #(
        .CYCLE_LEN (CYCLE_LEN),
        .INT_LEN   (INT_LEN),
        .DE_LEN    (DE_LEN),
        .ZI_LEN    (ZI_LEN),
        .ZI_OVR_LEN(ZI_OVR_LEN)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_hold_i (run_hold_i),
        .cmp_i      (cmp_i),
        .phase_o    (phase),
        .pol_o      (pol_o),
        .ovr_cyc_o  (ovr_cyc),
        .int_start_o(int_start),
        .de_start_o (de_start),
        .de_end_o   (de_end),
        .cnt_inc_o  (cnt_inc)
    );

    dss_bcd_counter #(
        .NDIG(NDIG)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(de_start),
        .inc_i(cnt_inc),
        .bcd_o(cnt_bcd)
    );

    dss_result_reg #(
        .NDIG   (NDIG),
        .UND_LIM(UND_LIM)
    ) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .de_end_i   (de_end),
        .ovr_cyc_i  (ovr_cyc),
        .int_start_i(int_start),
        .de_start_i (de_start),
        .cnt_i      (cnt_bcd),
        .bcd_o      (bcd_o),
        .ovr_o      (ovr_o),
        .und_o      (und_o),
        .rdy_o      (rdy_o)
    );

    // Phase decode to switch selects and busy.
    always_comb begin
        phase_sel_o = 4'b0000;
        case (phase)
            PH_AZ:   phase_sel_o = 4'b0001;
            PH_INT:  phase_sel_o = 4'b0010;
            PH_DE:   phase_sel_o = 4'b0100;
            default: phase_sel_o = 4'b1000;
        endcase
        busy_o = (phase == PH_INT) || (phase == PH_DE);
    end

endmodule

// File: rtl/dss_checker.sv
// Module: protocol checker for dslope_seq, attached by bind.
// Watches only top-level ports; all properties are disabled in reset.
module dss_checker #(
    parameter int NDIG = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        phase_sel_o,
    input logic              busy_o,
    input logic [4*NDIG-1:0] bcd_o,
    input logic              pol_o,
    input logic              ovr_o,
    input logic              und_o,
    input logic              rdy_o
);

    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_sel_o) == 1);                                      // R1
    AST_AZ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        phase_sel_o[0] |=> (phase_sel_o[0] || phase_sel_o[1]));             // R1
    AST_INT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        phase_sel_o[1] |=> (phase_sel_o[1] || phase_sel_o[2]));             // R1
    AST_DE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        phase_sel_o[2] |=> (phase_sel_o[2] || phase_sel_o[3]));             // R1
    AST_ZI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        phase_sel_o[3] |=> (phase_sel_o[3] || phase_sel_o[0]));             // R1
    AST_BUSY_FALL_ZI: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> phase_sel_o[3]);                                  // R7
    AST_RDY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |=> rdy_o);                                           // R8
    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o);                                                  // R8
    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_o |-> $stable(bcd_o));                                         // R8
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_sel_o[2]) |-> !ovr_o);                                  // R9
    AST_UND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_sel_o[1]) |-> !und_o);                                  // R10
    AST_POL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(phase_sel_o[2]) |-> $stable(pol_o));                         // R11

endmodule

bind dslope_seq dss_checker #(.NDIG(NDIG)) u_dss_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_sel_o(phase_sel_o),
    .busy_o     (busy_o),
    .bcd_o      (bcd_o),
    .pol_o      (pol_o),
    .ovr_o      (ovr_o),
    .und_o      (und_o),
    .rdy_o      (rdy_o)
);

// File: tb/dslope_seq_tb_top.sv
// Bench: behavioural reference model compared with the design every clock,
// plus directed checks on period, hold and restart. Scaled-down timing.
module dslope_seq_tb_top;

    localparam int NDIG = 5;
    localparam int CYC  = 402;
    localparam int INTL = 100;
    localparam int DEL  = 201;
    localparam int ZIL  = 8;
    localparam int ZOL  = 62;
    localparam int UND  = 18;
    localparam int NSC  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_hold_i = 1'b1;
    logic              cmp_i = 1'b0;
    logic [3:0]        phase_sel_o;
    logic              busy_o;
    logic [4*NDIG-1:0] bcd_o;
    logic              pol_o;
    logic              ovr_o;
    logic              und_o;
    logic              rdy_o;

    int total = 0;
    int bad   = 0;
    int cyc_n = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dslope_seq #(
        .NDIG(NDIG), .CYCLE_LEN(CYC), .INT_LEN(INTL), .DE_LEN(DEL),
        .ZI_LEN(ZIL), .ZI_OVR_LEN(ZOL), .UND_LIM(UND)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .run_hold_i(run_hold_i), .cmp_i(cmp_i),
        .phase_sel_o(phase_sel_o), .busy_o(busy_o), .bcd_o(bcd_o),
        .pol_o(pol_o), .ovr_o(ovr_o), .und_o(und_o), .rdy_o(rdy_o)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [4*NDIG-1:0] to_bcd(input int v);
        logic [4*NDIG-1:0] r;
        int x;
        x = v;
        r = '0;
        for (int d = 0; d < NDIG; d++) begin
            r[4*d +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Reference model state (0 az, 1 int, 2 de, 3 zi)
    int m_st = 0, m_pos = 0, m_tick = 0, m_cnt = 0;
    bit m_hold = 1, m_pol = 0, m_ovc = 0, m_ld = 0;
    int m_res = 0;
    bit m_or = 0, m_ur = 0, m_rdy = 0;
    bit cmp_en = 0;

    always @(posedge clk) begin
        bit nrdy;
        bit zc;
        cyc_n++;
        cmp_en = 1'b1;
        if (!rst_n) begin
            m_st = 0; m_pos = 0; m_tick = 0; m_cnt = 0; m_hold = 1;
            m_pol = 0; m_ovc = 0; m_ld = 0; m_res = 0; m_or = 0; m_ur = 0; m_rdy = 0;
        end else begin
            nrdy = 1'b0;
            if (m_ld) begin
                m_res = m_cnt; m_or = m_ovc; m_ur = !m_ovc && (m_cnt <= UND); nrdy = 1'b1;
            end
            m_ld = 1'b0;
            case (m_st)
                0: if (m_hold || m_pos == CYC - 1) begin
                       if (run_hold_i) begin
                           m_st = 1; m_pos = 0; m_tick = 0; m_hold = 0; m_ur = 0;
                       end else m_hold = 1;
                   end else m_pos++;
                1: begin
                       m_pos++;
                       if (m_tick == INTL - 1) begin
                           m_st = 2; m_tick = 0; m_pol = cmp_i; m_cnt = 0; m_or = 0;
                       end else m_tick++;
                   end
                2: begin
                       m_pos++;
                       zc = (cmp_i != m_pol);
                       if (zc) begin
                           m_st = 3; m_tick = 0; m_ovc = 0; m_ld = 1;
                       end else begin
                           if (m_tick != 0) m_cnt++;
                           if (m_tick == DEL - 1) begin
                               m_st = 3; m_tick = 0; m_ovc = 1; m_ld = 1;
                           end else m_tick++;
                       end
                   end
                default: begin
                       m_pos++;
                       if (m_tick == (m_ovc ? ZOL : ZIL) - 1) begin
                           m_st = 0; m_tick = 0;
                       end else m_tick++;
                   end
            endcase
            m_rdy = nrdy;
        end
        if (cyc_n > 60000) begin
            chk(1'b0, "watchdog", cyc_n, 60000);
            finish_run();
        end
    end

    // Scenarios: sign and de-integrate tick of the crossing (-1 = none)
    bit sc_pol [NSC] = '{1, 0, 1, 0, 1, 1, 0, 1, 0, 1};
    int sc_tc  [NSC] = '{0, 5, 19, 20, 200, -1, -1, 1, 150, -1};
    int sc_i = 0;
    bit cur_p = 1;
    int cur_tc = 0;

    bit fr = 1'b1;
    int int_starts = 0;
    int last_start = -1;
    int int_len = 0;
    bit prev_int = 1'b0;

    // Compare with the model, then drive the comparator for the next edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(phase_sel_o == 4'(1 << m_st), "R1 phase", phase_sel_o, 1 << m_st);
            chk(busy_o == (m_st == 1 || m_st == 2), "R7 busy", busy_o, m_st == 1 || m_st == 2);
            chk(bcd_o == to_bcd(m_res), "R5 R6 reading", bcd_o, to_bcd(m_res));
            chk(pol_o == m_pol, "R11 polarity", pol_o, m_pol);
            chk(ovr_o == m_or, "R6 R9 overrange", ovr_o, m_or);
            chk(und_o == m_ur, "R10 underrange", und_o, m_ur);
            chk(rdy_o == m_rdy, "R8 ready", rdy_o, m_rdy);
            // R2: integrate length and free-run period
            if (phase_sel_o[1]) int_len++;
            if (prev_int && !phase_sel_o[1]) begin
                chk(int_len == INTL, "R2 integrate length", int_len, INTL);
                int_len = 0;
            end
            if (phase_sel_o[1] && !prev_int) begin
                if (fr && last_start >= 0)
                    chk(cyc_n - last_start == CYC, "R2 period", cyc_n - last_start, CYC);
                last_start = cyc_n;
                int_starts++;
            end
            prev_int = phase_sel_o[1];
        end
        if (m_st == 1 && m_tick == 0) begin
            cur_p  = sc_pol[sc_i % NSC];
            cur_tc = sc_tc[sc_i % NSC];
            sc_i++;
        end
        if (m_st == 2 && cur_tc >= 0 && m_tick >= cur_tc) cmp_i <= !cur_p;
        else                                             cmp_i <= cur_p;
    end

    logic [4*NDIG-1:0] held;

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(phase_sel_o == 4'b0001, "R12 reset phase", phase_sel_o, 1);
        chk({busy_o, pol_o, ovr_o, und_o, rdy_o} == 5'b0, "R12 reset flags",
            {busy_o, pol_o, ovr_o, und_o, rdy_o}, 0);
        chk(bcd_o == '0, "R12 reset reading", bcd_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: waiting after reset, run/hold high starts integrate at once
        chk(phase_sel_o == 4'b0010, "R12 start after reset", phase_sel_o, 2);

        while (int_starts < 11) @(negedge clk);
        fr = 1'b0;
        run_hold_i = 1'b0;
        while (!m_hold) @(negedge clk);
        @(negedge clk);
        held = bcd_o;
        repeat (100) @(negedge clk);
        chk(phase_sel_o == 4'b0001, "R3 holding in auto-zero", phase_sel_o, 1);
        chk(bcd_o == held, "R3 reading kept", bcd_o, held);

        // R4: pulse while holding starts integrate next clock
        run_hold_i = 1'b1;
        @(negedge clk);
        run_hold_i = 1'b0;
        chk(phase_sel_o == 4'b0010, "R4 restart", phase_sel_o, 2);

        // R4: pulse during the running cycle is ignored
        while (m_st != 2) @(negedge clk);
        run_hold_i = 1'b1;
        @(negedge clk);
        run_hold_i = 1'b0;
        while (!m_hold) @(negedge clk);
        repeat (60) @(negedge clk);
        chk(phase_sel_o == 4'b0001, "R4 mid-cycle pulse ignored", phase_sel_o, 1);

        // restart once more and let the result land
        run_hold_i = 1'b1;
        @(negedge clk);
        run_hold_i = 1'b0;
        while (!m_hold) @(negedge clk);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule